// File: doc/BRIEF.md
# PCM Sample Rate Doubler

This block sits in an audio transmit path between a sample queue and a pulse-width output stage. It accepts signed 24-bit PCM samples on a valid/ready handshake. It either forwards them unchanged or doubles the sample rate by emitting two output samples for every input sample. The output also uses a valid/ready handshake.

A 32-bit control word has two live bits: an enable bit (bit 31) and a mode bit (bit 0). With the enable bit clear, the block is a plain pass-through. With it set, the mode bit chooses how the extra sample is made. In repeat mode the extra sample is a copy of the input. In average mode it is the mean of the previous and the current input.

Configuration is sampled only when a new input is taken, so an output pair is never split across two settings. The block throttles its input while the second sample of a pair is still waiting, so no sample is dropped or repeated when the consumer stalls.

Top module: `pcm_rate_doubler`

## Requirements
- R1: After reset the control word reads 0x00000000, out_valid is 0 and in_ready is 1.
- R2: The control readback holds the enable in bit 31 and the mode in bit 0 (0 = repeat, 1 = average). Bits 30 to 1 always read 0, whatever was written.
- R3: With the enable bit 0, each accepted input produces exactly one output equal to it bit for bit.
- R4: With the enable bit 1 and mode 0, each accepted input is emitted twice in a row.
- R5: With the enable bit 1 and mode 1, each input N produces two outputs. The first is floor((N-1 + N)/2), with both samples taken as signed two's complement. The second is N itself.
- R6: The stored previous sample is zero after reset and is cleared whenever a write turns the enable bit from 0 to 1. The first average after enabling is therefore floor(N/2).
- R7: The mode bit has no effect while the enable bit is 0: output equals input, one per input.
- R8: While the second output of a pair is pending, in_ready is 0. While out_valid is 1 and out_ready is 0, out_data holds still. Under any stall pattern every input appears in the output stream in order, with nothing lost or duplicated.
- R9: A control write made while a pair is pending does not alter that pair. The new setting applies from the next accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write value |
| ctrl_rdata | output | 32 | Control word readback |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take an input sample |
| in_data | input | 24 | Input sample, signed |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer takes the output sample |
| out_data | output | 24 | Output sample, signed |

## Verification
The averaging path is tried with a sequence chosen to separate rounding and overflow errors. It pairs small positive values, values straddling zero, two negative values whose mean must round downward, the largest positive value twice, and a swing from the most negative value to one. Each of these exposes a different mistake: a missing sign extension, a truncation toward zero, or a lost carry bit. Repeat mode, pass-through and pass-through with the mode bit set are each sent short distinct streams, so that a wrong output count tells them apart. A stall pattern on out_ready and a write made mid-pair show whether the pairing survives backpressure and a change of setting.

// File: rtl/pcm_dbl_pkg.sv
package pcm_dbl_pkg;
  localparam int CSR_W    = 32;
  localparam int EN_BIT   = CSR_W - 1;
  localparam int MODE_BIT = 0;

  typedef enum logic {
    MODE_REPEAT  = 1'b0,
    MODE_AVERAGE = 1'b1
  } dbl_mode_e;

  typedef struct packed {
    logic      en;
    dbl_mode_e mode;
  } dbl_cfg_t;
endpackage

// File: rtl/pcm_dbl_ctrl.sv
module pcm_dbl_ctrl
  import pcm_dbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CSR_W-1:0] wdata,
  output logic [CSR_W-1:0] rdata,
  output dbl_cfg_t         cfg,
  output logic             en_rise
);
  logic en_q;
  logic mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
    end else if (we) begin
      en_q   <= wdata[EN_BIT];
      mode_q <= wdata[MODE_BIT];
    end
  end

  // a write that switches the doubler on from off
  assign en_rise = we && wdata[EN_BIT] && !en_q;

  always_comb begin
    rdata           = '0;
    rdata[EN_BIT]   = en_q;
    rdata[MODE_BIT] = mode_q;
  end

  assign cfg.en   = en_q;
  assign cfg.mode = dbl_mode_e'(mode_q);
endmodule

// File: rtl/pcm_dbl_avg.sv
module pcm_dbl_avg #(
  parameter int DATA_W = 24
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int SUM_W = DATA_W + 1;

  logic [SUM_W-1:0] sum;

  // sign-extend both, add, and drop the LSB: floor of the signed mean
  assign sum = {a[DATA_W-1], a} + {b[DATA_W-1], b};
  assign y   = sum[SUM_W-1:1];
endmodule

// File: rtl/pcm_dbl_core.sv
module pcm_dbl_core
  import pcm_dbl_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  dbl_cfg_t          cfg,
  input  logic              en_rise,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              pend_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] avg_w;
  logic              take;

  pcm_dbl_avg #(.DATA_W(DATA_W)) u_avg (
    .a (prev_q),
    .b (in_data),
    .y (avg_w)
  );

  assign in_ready = !pend_q && (!out_valid || out_ready);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
      prev_q      <= '0;
    end else begin
      if (take) begin
        prev_q    <= in_data;
        out_valid <= 1'b1;
        if (!cfg.en) begin
          out_data <= in_data;
        end else begin
          pend_q      <= 1'b1;
          pend_data_q <= in_data;
          out_data    <= (cfg.mode == MODE_AVERAGE) ? avg_w : in_data;
        end
      end else if (out_valid && out_ready) begin
        if (pend_q) begin
          out_data <= pend_data_q;
          pend_q   <= 1'b0;
        end else begin
          out_valid <= 1'b0;
        end
      end
      // enabling starts the averaging history from zero
      if (en_rise) prev_q <= '0;
    end
  end
endmodule

// File: rtl/pcm_rate_doubler.sv
module pcm_rate_doubler
  import pcm_dbl_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CSR_W-1:0]  ctrl_wdata,
  output logic [CSR_W-1:0]  ctrl_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  dbl_cfg_t cfg;
  logic     en_rise;

  pcm_dbl_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .we      (ctrl_we),
    .wdata   (ctrl_wdata),
    .rdata   (ctrl_rdata),
    .cfg     (cfg),
    .en_rise (en_rise)
  );

  pcm_dbl_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .en_rise   (en_rise),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/pcm_dbl_checker.sv
module pcm_dbl_checker #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       ctrl_rdata,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctrl_rdata == 32'h0) && !out_valid);

  assert_unused_bits_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl_rdata[30:1] == '0);

  assert_bypass_copy_R3: assert property (@(posedge clk) disable iff (rst)
    acc && !ctrl_rdata[31] |=> out_valid && out_data == $past(in_data));

  assert_repeat_first_R4: assert property (@(posedge clk) disable iff (rst)
    acc && ctrl_rdata[31] && !ctrl_rdata[0] |=> out_valid && out_data == $past(in_data));

  assert_repeat_second_R4: assert property (@(posedge clk) disable iff (rst)
    acc && ctrl_rdata[31] && !ctrl_rdata[0] ##1 out_valid && out_ready
      |=> out_valid && out_data == $past(in_data, 2));

  assert_pair_blocks_input_R8: assert property (@(posedge clk) disable iff (rst)
    acc && ctrl_rdata[31] |=> !in_ready);

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind pcm_rate_doubler pcm_dbl_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_pcm_rate_doubler.sv
module sim_pcm_rate_doubler;
  localparam int CLK_PERIOD = 10;
  localparam int NAVG = 9;
  // {input sample, expected first output of its pair}
  localparam logic [47:0] AVG_TBL [0:NAVG-1] = '{
    {24'h000010, 24'h000008},
    {24'h000021, 24'h000018},
    {24'hFFFFFF, 24'h000010},
    {24'hFFFFFE, 24'hFFFFFE},
    {24'h7FFFFF, 24'h3FFFFE},
    {24'h7FFFFF, 24'h7FFFFF},
    {24'h800000, 24'hFFFFFF},
    {24'h800000, 24'h800000},
    {24'h000001, 24'hC00000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_data = '0;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] out_data;

  logic hold = 1'b0;
  logic bp   = 1'b0;
  int   cyc  = 0;
  int   checks = 0;
  int   errors = 0;
  logic [23:0] got [0:63];
  int   ngot = 0;
  int   nb;
  logic [23:0] held;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign out_ready = hold ? 1'b0 : (bp ? (cyc % 3 != 0) : 1'b1);

  pcm_rate_doubler u0 (.*);

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && ngot < 64) begin
      got[ngot] = out_data;
      ngot++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(posedge clk); #1;
    ctrl_we = 1'b0;
  endtask

  task automatic send(input logic [23:0] d);
    logic ok;
    in_data = d; in_valid = 1'b1;
    do begin
      @(negedge clk); ok = in_ready;
      @(posedge clk); #1;
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (10) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 ctrl", ctrl_rdata, 32'h0);
    chk("R1 out_valid", {31'h0, out_valid}, 32'h0);
    chk("R1 in_ready", {31'h0, in_ready}, 32'h1);
    @(posedge clk); #1;

    // R2: only enable and mode bits stick
    wr_ctrl(32'hFFFF_FFFF);
    @(negedge clk);
    chk("R2 readback", ctrl_rdata, 32'h8000_0001);
    @(posedge clk); #1;
    wr_ctrl(32'h7FFF_FFFE);
    @(negedge clk);
    chk("R2 readback zeros", ctrl_rdata, 32'h0);
    @(posedge clk); #1;

    // R3: bypass
    nb = ngot;
    send(24'h123456); send(24'hABCDEF); send(24'h000001);
    drain();
    chk("R3 count", ngot - nb, 3);
    chk("R3 s0", {8'h0, got[nb]}, 32'h123456);
    chk("R3 s1", {8'h0, got[nb+1]}, 32'hABCDEF);
    chk("R3 s2", {8'h0, got[nb+2]}, 32'h000001);

    // R7: mode bit set while disabled
    wr_ctrl(32'h0000_0001);
    nb = ngot;
    send(24'h000100); send(24'hFFF000);
    drain();
    chk("R7 count", ngot - nb, 2);
    chk("R7 s0", {8'h0, got[nb]}, 32'h000100);
    chk("R7 s1", {8'h0, got[nb+1]}, 32'hFFF000);

    // R4: repetition
    wr_ctrl(32'h8000_0000);
    nb = ngot;
    send(24'h0000AA); send(24'h5555BB); send(24'hF0F0F0);
    drain();
    chk("R4 count", ngot - nb, 6);
    for (int i = 0; i < 3; i++) begin
      chk("R4 pair equal", {8'h0, got[nb+2*i]}, {8'h0, got[nb+2*i+1]});
    end
    chk("R4 s0", {8'h0, got[nb]}, 32'h0000AA);
    chk("R4 s2", {8'h0, got[nb+2]}, 32'h5555BB);
    chk("R4 s4", {8'h0, got[nb+4]}, 32'hF0F0F0);

    // R6: disable, load a nonzero history in bypass, then enable averaging
    wr_ctrl(32'h0);
    send(24'h400000);
    drain();
    wr_ctrl(32'h8000_0001);
    nb = ngot;
    for (int i = 0; i < NAVG; i++) send(AVG_TBL[i][47:24]);
    drain();
    chk("R5 count", ngot - nb, 2*NAVG);
    for (int i = 0; i < NAVG; i++) begin
      chk(i == 0 ? "R6 first average" : "R5 average",
          {8'h0, got[nb+2*i]}, {8'h0, AVG_TBL[i][23:0]});
      chk("R5 sample", {8'h0, got[nb+2*i+1]}, {8'h0, AVG_TBL[i][47:24]});
    end

    // R8: stall pattern on the consumer side, averaging continues from 0x000001
    bp = 1'b1;
    nb = ngot;
    send(24'h000003); send(24'h000005); send(24'hFFFFF9);
    drain(); drain();
    bp = 1'b0;
    chk("R8 count", ngot - nb, 6);
    chk("R8 o0", {8'h0, got[nb]},   32'h000002);
    chk("R8 o1", {8'h0, got[nb+1]}, 32'h000003);
    chk("R8 o2", {8'h0, got[nb+2]}, 32'h000004);
    chk("R8 o3", {8'h0, got[nb+3]}, 32'h000005);
    chk("R8 o4", {8'h0, got[nb+4]}, 32'hFFFFFF);
    chk("R8 o5", {8'h0, got[nb+5]}, 32'hFFFFF9);

    // R8 + R9: hold the consumer, change config mid-pair
    wr_ctrl(32'h8000_0000);
    hold = 1'b1;
    nb = ngot;
    send(24'h0ABCDE);
    @(negedge clk);
    chk("R8 ready low while pending", {31'h0, in_ready}, 32'h0);
    held = out_data;
    wr_ctrl(32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 data held", {8'h0, out_data}, {8'h0, held});
    chk("R8 valid held", {31'h0, out_valid}, 32'h1);
    @(posedge clk); #1;
    hold = 1'b0;
    drain();
    send(24'h00BEEF);
    drain();
    chk("R9 count", ngot - nb, 3);
    chk("R9 pair first", {8'h0, got[nb]}, 32'h0ABCDE);
    chk("R9 pair second", {8'h0, got[nb+1]}, 32'h0ABCDE);
    chk("R9 new config", {8'h0, got[nb+2]}, 32'h00BEEF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule